// File: doc/BRIEF.md
# Receive Powersave Wake Sequencer

This block duty-cycles a receive chain to save power. When the host writes the powersave code into the mode field, the sequencer turns off the RF front end and the internal receive circuits for a programmed number of timebase ticks. It then turns both back on and waits a short settle time before it accepts any measurement.

After settling, the receiver must pass three measurements in a fixed order. The first is raw in-band energy, the second is the level after the channel filter, and the third is a squelch figure: the energy above the wanted signal bandwidth. Each stage waits for its own valid strobe within a tick-based time window. A failed comparison, or a missing strobe by the end of the window, sends the block back to a timed sleep. When all three stages pass, the receiver stays on until the host writes the mode field again.

Frame-sync search is enabled whenever the receiver is on and settled. A burst whose opening sync fell inside a sleep period can therefore still be picked up partway through.

Top module: `rxps_wake_seq`

## Requirements
- R1: A mode write (`mode_wr` high) always takes priority. Value 0x9 moves the block to SLEEP (state code 1) on the next edge and restarts the sleep count. Any other value moves it to IDLE (code 0).
- R2: SLEEP lasts until `cfg_sleep_ticks` ticks have been seen in the cycles after entry. The block then moves to SETTLE (code 2) on the next edge. A value of 0 gives a single cycle of SLEEP.
- R3: SETTLE counts `cfg_settle_ticks` ticks in the same way and then moves to ENERGY (code 3). Measurement strobes have no effect during SETTLE.
- R4: In ENERGY, `energy_vld` with `energy_val` >= `cfg_energy_thr` moves the block to CHAN (code 4). A lower value moves it back to SLEEP.
- R5: In CHAN, `chan_vld` with `chan_val` >= `cfg_chan_thr` moves the block to SQUELCH (code 5). A lower value moves it back to SLEEP.
- R6: In SQUELCH, `sq_vld` with `sq_val` < `cfg_sq_thr` moves the block to RXON (code 6). A value at or above the threshold moves it back to SLEEP.
- R7: Each check stage has a window of `cfg_timeout_ticks` ticks. If the stage's own strobe has not arrived when the window ends, the block returns to SLEEP.
- R8: RXON is held until the next mode write. Strobes and ticks have no effect on it.
- R9: `fe_pwr_en` and `core_pwr_en` are low only in SLEEP. `sync_search_en` is low in SLEEP and SETTLE and high in every other state. `rx_on` is high only in RXON. `state_o` carries the state code.
- R10: In a check stage, the strobes that belong to the other stages are ignored.
- R11: Reset is synchronous and active high. It puts the block in IDLE with both power enables and sync search high and `rx_on` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Host mode-register write strobe |
| mode_val | input | 4 | Mode field value written |
| tick | input | 1 | Timebase tick, one cycle wide |
| cfg_sleep_ticks | input | 16 | Sleep duration in ticks |
| cfg_settle_ticks | input | 8 | Settle delay after power-up in ticks |
| cfg_timeout_ticks | input | 8 | Per-stage measurement window in ticks |
| cfg_energy_thr | input | MW | In-band energy threshold |
| cfg_chan_thr | input | MW | Channel-filtered level threshold |
| cfg_sq_thr | input | MW | Out-of-band noise threshold |
| energy_vld | input | 1 | Energy measurement strobe |
| energy_val | input | MW | Energy measurement |
| chan_vld | input | 1 | Channel level strobe |
| chan_val | input | MW | Channel level measurement |
| sq_vld | input | 1 | Squelch measurement strobe |
| sq_val | input | MW | Out-of-band noise measurement |
| fe_pwr_en | output | 1 | Front-end power enable |
| core_pwr_en | output | 1 | Internal receive circuit power enable |
| sync_search_en | output | 1 | Frame-sync search enable |
| rx_on | output | 1 | Powersave qualified, receiver latched on |
| state_o | output | 3 | Current state code |

## Verification
The assertions assume that `tick` and the measurement strobes are single-cycle pulses driven between clock edges. They also assume that `mode_val` is meaningful only while `mode_wr` is high, and that configuration is held steady while a count runs. The stimulus drives every input on the falling edge and changes configuration only between runs. It also drives strobes for the wrong stage, strobes during SETTLE, and values equal to each threshold, so the properties on state order and power are exercised where they are most likely to break.

// File: rtl/rxps_pkg.sv
package rxps_pkg;

    typedef enum logic [2:0] {
        PS_IDLE    = 3'd0,
        PS_SLEEP   = 3'd1,
        PS_SETTLE  = 3'd2,
        PS_ENERGY  = 3'd3,
        PS_CHAN    = 3'd4,
        PS_SQUELCH = 3'd5,
        PS_RXON    = 3'd6
    } ps_state_e;

    localparam logic [3:0] MODE_POWERSAVE = 4'h9;
    localparam int         N_STAGES       = 3;

    typedef struct packed {
        logic fe;
        logic core;
        logic sync;
        logic rx_on;
    } ps_out_s;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic logic is_check(input ps_state_e s);
        return (s == PS_ENERGY) || (s == PS_CHAN) || (s == PS_SQUELCH);
    endfunction

    function automatic ps_out_s outs_for(input ps_state_e s);
        ps_out_s o;
        o.fe    = (s != PS_SLEEP);
        o.core  = (s != PS_SLEEP);
        o.sync  = (s != PS_SLEEP) && (s != PS_SETTLE);
        o.rx_on = (s == PS_RXON);
        return o;
    endfunction

endpackage

// File: rtl/rxps_timer.sv
module rxps_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          tick,
    output logic          expired
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/rxps_stage_cmp.sv
module rxps_stage_cmp #(
    parameter int MW         = 16,
    parameter bit PASS_BELOW = 1'b0
) (
    input  logic          en,
    input  logic          vld,
    input  logic [MW-1:0] val,
    input  logic [MW-1:0] thr,
    output logic          hit_pass,
    output logic          hit_fail
);
    logic good;

    generate
        if (PASS_BELOW) begin : g_below
            assign good = (val < thr);
        end else begin : g_atleast
            assign good = (val >= thr);
        end
    endgenerate

    assign hit_pass = en & vld & good;
    assign hit_fail = en & vld & ~good;
endmodule

// File: rtl/rxps_ctrl.sv
module rxps_ctrl
    import rxps_pkg::*;
#(
    parameter int CW       = 16,
    parameter int SLEEP_W  = 16,
    parameter int SETTLE_W = 8,
    parameter int TO_W     = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                mode_wr,
    input  logic [3:0]          mode_val,
    input  logic [SLEEP_W-1:0]  sleep_ticks,
    input  logic [SETTLE_W-1:0] settle_ticks,
    input  logic [TO_W-1:0]     timeout_ticks,
    input  logic                expired,
    input  logic [N_STAGES-1:0] stage_pass,
    input  logic [N_STAGES-1:0] stage_fail,
    output ps_state_e           state,
    output logic                tmr_load,
    output logic [CW-1:0]       tmr_val,
    output ps_out_s             outs
);
    ps_state_e     st_q, st_d;
    ps_out_s       out_q;
    logic [CW-1:0] sleep_ext, settle_ext, to_ext;

    assign sleep_ext  = CW'(sleep_ticks);
    assign settle_ext = CW'(settle_ticks);
    assign to_ext     = CW'(timeout_ticks);

    always_comb begin
        st_d     = st_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (mode_wr) begin
            tmr_load = 1'b1;
            tmr_val  = sleep_ext;
            st_d     = (mode_val == MODE_POWERSAVE) ? PS_SLEEP : PS_IDLE;
        end else begin
            case (st_q)
                PS_SLEEP: begin
                    if (expired) begin
                        st_d     = PS_SETTLE;
                        tmr_load = 1'b1;
                        tmr_val  = settle_ext;
                    end
                end
                PS_SETTLE: begin
                    if (expired) begin
                        st_d     = PS_ENERGY;
                        tmr_load = 1'b1;
                        tmr_val  = to_ext;
                    end
                end
                PS_ENERGY, PS_CHAN, PS_SQUELCH: begin
                    if (|stage_pass) begin
                        tmr_load = 1'b1;
                        tmr_val  = to_ext;
                        st_d     = (st_q == PS_SQUELCH) ? PS_RXON
                                                        : ps_state_e'(st_q + 3'd1);
                    end else if ((|stage_fail) || expired) begin
                        st_d     = PS_SLEEP;
                        tmr_load = 1'b1;
                        tmr_val  = sleep_ext;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= PS_IDLE;
            out_q <= outs_for(PS_IDLE);
        end else begin
            st_q  <= st_d;
            out_q <= outs_for(st_d);
        end
    end

    assign state = st_q;
    assign outs  = out_q;
endmodule

// File: rtl/rxps_wake_seq.sv
module rxps_wake_seq
    import rxps_pkg::*;
#(
    parameter int MW       = 16,
    parameter int SLEEP_W  = 16,
    parameter int SETTLE_W = 8,
    parameter int TO_W     = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                mode_wr,
    input  logic [3:0]          mode_val,
    input  logic                tick,
    input  logic [SLEEP_W-1:0]  cfg_sleep_ticks,
    input  logic [SETTLE_W-1:0] cfg_settle_ticks,
    input  logic [TO_W-1:0]     cfg_timeout_ticks,
    input  logic [MW-1:0]       cfg_energy_thr,
    input  logic [MW-1:0]       cfg_chan_thr,
    input  logic [MW-1:0]       cfg_sq_thr,
    input  logic                energy_vld,
    input  logic [MW-1:0]       energy_val,
    input  logic                chan_vld,
    input  logic [MW-1:0]       chan_val,
    input  logic                sq_vld,
    input  logic [MW-1:0]       sq_val,
    output logic                fe_pwr_en,
    output logic                core_pwr_en,
    output logic                sync_search_en,
    output logic                rx_on,
    output logic [2:0]          state_o
);
    localparam int CW = max3(SLEEP_W, SETTLE_W, TO_W);

    ps_state_e           state;
    ps_out_s             outs;
    logic                tmr_load, expired;
    logic [CW-1:0]       tmr_val;
    logic [N_STAGES-1:0] stg_vld, stg_en, stg_pass, stg_fail;
    logic [MW-1:0]       stg_val [N_STAGES];
    logic [MW-1:0]       stg_thr [N_STAGES];

    assign stg_vld    = {sq_vld, chan_vld, energy_vld};
    assign stg_val[0] = energy_val;
    assign stg_val[1] = chan_val;
    assign stg_val[2] = sq_val;
    assign stg_thr[0] = cfg_energy_thr;
    assign stg_thr[1] = cfg_chan_thr;
    assign stg_thr[2] = cfg_sq_thr;

    genvar k;
    generate
        for (k = 0; k < N_STAGES; k++) begin : g_stage
            assign stg_en[k] = (state == ps_state_e'(PS_ENERGY + k));
            rxps_stage_cmp #(
                .MW         (MW),
                .PASS_BELOW (k == N_STAGES - 1)
            ) u_cmp (
                .en       (stg_en[k]),
                .vld      (stg_vld[k]),
                .val      (stg_val[k]),
                .thr      (stg_thr[k]),
                .hit_pass (stg_pass[k]),
                .hit_fail (stg_fail[k])
            );
        end
    endgenerate

    rxps_timer #(.CW(CW)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .tick     (tick),
        .expired  (expired)
    );

    rxps_ctrl #(
        .CW       (CW),
        .SLEEP_W  (SLEEP_W),
        .SETTLE_W (SETTLE_W),
        .TO_W     (TO_W)
    ) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .mode_wr       (mode_wr),
        .mode_val      (mode_val),
        .sleep_ticks   (cfg_sleep_ticks),
        .settle_ticks  (cfg_settle_ticks),
        .timeout_ticks (cfg_timeout_ticks),
        .expired       (expired),
        .stage_pass    (stg_pass),
        .stage_fail    (stg_fail),
        .state         (state),
        .tmr_load      (tmr_load),
        .tmr_val       (tmr_val),
        .outs          (outs)
    );

    assign fe_pwr_en      = outs.fe;
    assign core_pwr_en    = outs.core;
    assign sync_search_en = outs.sync;
    assign rx_on          = outs.rx_on;
    assign state_o        = state;
endmodule

// File: rtl/rxps_wake_seq_chk.sv
module rxps_wake_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       mode_wr,
    input logic [3:0] mode_val,
    input logic       sq_vld,
    input logic       fe_pwr_en,
    input logic       core_pwr_en,
    input logic       sync_search_en,
    input logic       rx_on,
    input logic [2:0] state_o
);
    p_enter_sleep_r1: assert property (@(posedge clk) disable iff (rst)
        (mode_wr && mode_val == 4'h9) |=> (state_o == 3'd1 && !fe_pwr_en));

    p_leave_ps_r1: assert property (@(posedge clk) disable iff (rst)
        (mode_wr && mode_val != 4'h9) |=> (state_o == 3'd0 && fe_pwr_en && core_pwr_en));

    p_sleep_order_r2: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd1 && !mode_wr) |=> (state_o inside {3'd1, 3'd2}));

    p_settle_order_r3: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd2 && !mode_wr) |=> (state_o inside {3'd2, 3'd3}));

    p_energy_order_r4: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd3 && !mode_wr) |=> (state_o inside {3'd3, 3'd4, 3'd1}));

    p_chan_order_r5: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd4 && !mode_wr) |=> (state_o inside {3'd4, 3'd5, 3'd1}));

    p_rxon_cause_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_on) |-> ($past(state_o) == 3'd5 && $past(sq_vld)));

    p_rxon_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd6 && !mode_wr) |=> (state_o == 3'd6 && rx_on));

    p_sleep_dark_r9: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd1) |-> (!fe_pwr_en && !core_pwr_en && !sync_search_en));
endmodule

bind rxps_wake_seq rxps_wake_seq_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .mode_wr        (mode_wr),
    .mode_val       (mode_val),
    .sq_vld         (sq_vld),
    .fe_pwr_en      (fe_pwr_en),
    .core_pwr_en    (core_pwr_en),
    .sync_search_en (sync_search_en),
    .rx_on          (rx_on),
    .state_o        (state_o)
);

// File: tb/sim_rxps_wake_seq.sv
module sim_rxps_wake_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_wr = 1'b0;
    logic [3:0]  mode_val = 4'h0;
    logic        tick = 1'b0;
    logic [15:0] cfg_sleep = 16'd5;
    logic [7:0]  cfg_settle = 8'd3;
    logic [7:0]  cfg_to = 8'd4;
    logic [15:0] thr_e = 16'd100, thr_c = 16'd200, thr_s = 16'd50;
    logic        e_vld = 1'b0, c_vld = 1'b0, s_vld = 1'b0;
    logic [15:0] e_val = '0, c_val = '0, s_val = '0;
    logic        fe_pwr_en, core_pwr_en, sync_search_en, rx_on;
    logic [2:0]  state_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    rxps_wake_seq u0 (
        .clk (clk), .rst (rst), .mode_wr (mode_wr), .mode_val (mode_val), .tick (tick),
        .cfg_sleep_ticks (cfg_sleep), .cfg_settle_ticks (cfg_settle),
        .cfg_timeout_ticks (cfg_to), .cfg_energy_thr (thr_e), .cfg_chan_thr (thr_c),
        .cfg_sq_thr (thr_s), .energy_vld (e_vld), .energy_val (e_val),
        .chan_vld (c_vld), .chan_val (c_val), .sq_vld (s_vld), .sq_val (s_val),
        .fe_pwr_en (fe_pwr_en), .core_pwr_en (core_pwr_en),
        .sync_search_en (sync_search_en), .rx_on (rx_on), .state_o (state_o)
    );

    // free-running tick every third cycle
    int tdiv = 0;
    always @(negedge clk) begin
        tdiv = (tdiv == 2) ? 0 : tdiv + 1;
        tick <= (tdiv == 0);
    end

    // behavioural reference: state code and remaining count
    int m_st = 0;
    int m_cnt = 0;
    always @(posedge clk) begin
        if (rst) begin
            m_st = 0;
            m_cnt = 0;
        end else begin
            int nst;
            int lv;
            bit moved;
            nst = m_st;
            lv = 0;
            moved = 0;
            if (mode_wr) begin
                nst = (mode_val == 4'h9) ? 1 : 0;
                lv = cfg_sleep;
                moved = 1;
            end else if (m_st == 1 && m_cnt == 0) begin
                nst = 2; lv = cfg_settle; moved = 1;
            end else if (m_st == 2 && m_cnt == 0) begin
                nst = 3; lv = cfg_to; moved = 1;
            end else if (m_st >= 3 && m_st <= 5) begin
                bit v;
                bit ok;
                if (m_st == 3) begin v = e_vld; ok = (e_val >= thr_e); end
                else if (m_st == 4) begin v = c_vld; ok = (c_val >= thr_c); end
                else begin v = s_vld; ok = (s_val < thr_s); end
                if (v && ok) begin
                    nst = m_st + 1; lv = cfg_to; moved = 1;
                end else if (v || m_cnt == 0) begin
                    nst = 1; lv = cfg_sleep; moved = 1;
                end
            end
            if (moved) m_cnt = lv;
            else if (tick && m_cnt > 0) m_cnt = m_cnt - 1;
            m_st = nst;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string tag_for(input int s);
        case (s)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            5: return "R6";
            default: return "R8";
        endcase
    endfunction

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk(tag_for(m_st), int'(state_o), m_st);
            chk("R9 fe", int'(fe_pwr_en), int'(m_st != 1));
            chk("R9 core", int'(core_pwr_en), int'(m_st != 1));
            chk("R9 sync", int'(sync_search_en), int'(m_st != 1 && m_st != 2));
            chk("R9 rx_on", int'(rx_on), int'(m_st == 6));
        end
    end

    task automatic write_mode(input logic [3:0] v);
        @(negedge clk);
        mode_wr = 1'b1;
        mode_val = v;
        @(negedge clk);
        mode_wr = 1'b0;
    endtask

    task automatic wait_state(input int s, input string tag);
        bit hit;
        hit = 0;
        for (int i = 0; i < 400 && !hit; i++) begin
            @(negedge clk);
            if (int'(state_o) == s) hit = 1;
        end
        chk(tag, int'(hit), 1);
    endtask

    task automatic strobe(input int stage, input int v);
        @(negedge clk);
        case (stage)
            0: begin e_vld = 1'b1; e_val = 16'(v); end
            1: begin c_vld = 1'b1; c_val = 16'(v); end
            default: begin s_vld = 1'b1; s_val = 16'(v); end
        endcase
        @(negedge clk);
        e_vld = 1'b0; c_vld = 1'b0; s_vld = 1'b0;
    endtask

    task automatic finish_run;
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11: reset state
        chk("R11 state", int'(state_o), 0);
        chk("R11 power", int'(fe_pwr_en && core_pwr_en && sync_search_en), 1);
        chk("R11 rx_on", int'(rx_on), 0);

        // R1: non-powersave write stays idle
        write_mode(4'h3);
        chk("R1 idle", int'(state_o), 0);

        // R4: energy below threshold
        write_mode(4'h9);
        chk("R1 sleep", int'(state_o), 1);
        wait_state(3, "R3 reach energy");
        strobe(0, 40);
        chk("R4 low energy", int'(state_o), 1);

        // R4 boundary pass, R10 foreign strobe, R5 low level
        wait_state(3, "R2 reach energy");
        strobe(0, 100);
        chk("R4 equal passes", int'(state_o), 4);
        strobe(2, 0);
        chk("R10 foreign strobe", int'(state_o), 4);
        strobe(1, 150);
        chk("R5 low level", int'(state_o), 1);

        // R6: noisy squelch fails at threshold
        wait_state(3, "R6 reach energy");
        strobe(0, 500);
        strobe(1, 200);
        chk("R5 equal passes", int'(state_o), 5);
        strobe(2, 50);
        chk("R6 noisy", int'(state_o), 1);

        // full pass then R8 hold
        wait_state(3, "R6 reach energy again");
        strobe(0, 500);
        strobe(1, 900);
        strobe(2, 10);
        chk("R6 quiet passes", int'(state_o), 6);
        strobe(0, 1);
        strobe(1, 1);
        strobe(2, 999);
        repeat (40) @(negedge clk);
        chk("R8 held", int'(state_o), 6);
        chk("R8 rx_on", int'(rx_on), 1);

        // R7: no strobe in energy window
        write_mode(4'h9);
        wait_state(3, "R7 reach energy");
        wait_state(1, "R7 timeout to sleep");

        // R3: strobe during settle ignored
        wait_state(2, "R3 reach settle");
        strobe(0, 999);
        chk("R3 settle ignores", int'(state_o), 2);
        wait_state(3, "R3 settle done");
        strobe(1, 999);
        chk("R10 chan in energy", int'(state_o), 3);

        // R7: no strobe in channel window
        strobe(0, 999);
        wait_state(1, "R7 chan timeout");

        // R1: write during sleep returns to idle
        write_mode(4'h1);
        chk("R1 abort", int'(state_o), 0);

        // R2: zero sleep gives one cycle
        @(negedge clk);
        cfg_sleep = 16'd0;
        write_mode(4'h9);
        chk("R2 zero sleep entry", int'(state_o), 1);
        @(negedge clk);
        chk("R2 zero sleep exit", int'(state_o), 2);

        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule